// File: doc/BRIEF.md
# Configurable Edge-Triggered Distributed RAM

This block is a tiny single-port memory of the sort that sits inside one logic cell. It holds 32 bits, split into two 16-bit halves. A static mode input picks one of two organisations. In the dual narrow organisation, each half is its own 16x1 memory with its own address, data input and data output, and both halves share one write enable. In the single wide organisation, the two halves act together as one 32x1 memory. In that organisation the second data input is reused as the top address bit.

Writes are synchronous and behave like a register with a clock enable. Address, data and write enable are sampled on one chosen edge of the clock. The edge is the rising one by default, or the falling one when the polarity input is set. Reads are asynchronous: the addressed bit appears on the data outputs combinationally. A second output path can return the read data straight through, or registered on the write edge, or registered on the opposite clock edge. Those output registers clear on a synchronous, active-high reset. The array itself is never reset.

Top module: `cfg_dist_ram`

## Requirements
- R1: With `cfg_wide`=0, an active write edge with `we`=1 stores `din0` into half 0 at `addr_f` and `din1` into half 1 at `addr_g`.
- R2: With `cfg_wide`=0, `dout[0]` shows half 0 at `addr_f` and `dout[1]` shows half 1 at `addr_g`, combinationally, with no clock edge needed.
- R3: With `cfg_wide`=1, an active write edge with `we`=1 stores `din0` into word {`din1`,`addr_f`}. `din1`=0 selects half 0 and `din1`=1 selects half 1, so word n is the same bit as narrow location n mod 16 of half n/16. `addr_g` is ignored.
- R4: With `cfg_wide`=1, `dout[0]` shows word {`din1`,`addr_f`} combinationally and `dout[1]` is 0.
- R5: An edge with `we`=0 leaves every stored bit unchanged.
- R6: With `cfg_fall`=0, writes take effect only on rising clock edges. With `cfg_fall`=1, they take effect only on falling clock edges.
- R7: `oreg_sel` selects the `qout` source. Values 0 and 3 give `dout` unregistered. Value 1 gives `dout` captured on the active write edge. Value 2 gives `dout` captured on the opposite edge.
- R8: With `rst`=1, each output register clears to 0 on its own capture edge. Memory contents are not affected by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for writes and output registers |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| cfg_wide | input | 1 | Static organisation: 0 dual 16x1, 1 single 32x1 |
| cfg_fall | input | 1 | Static write-edge polarity: 0 rising, 1 falling |
| oreg_sel | input | 2 | Output path: 0/3 direct, 1 same edge, 2 opposite edge |
| we | input | 1 | Active-high write enable |
| addr_f | input | 4 | Address of half 0 (both halves in wide mode) |
| addr_g | input | 4 | Address of half 1 in narrow mode |
| din0 | input | 1 | Data for half 0, or the single data bit in wide mode |
| din1 | input | 1 | Data for half 1, or address bit 4 in wide mode |
| dout | output | 2 | Combinational read data |
| qout | output | 2 | Read data after the selected output path |

## Verification
A write is due on the first active edge while `we` is high. The combinational read must show the new bit right after that edge, with no further cycle. Each stimulus is therefore driven one nanosecond after a clock edge and held across both a rising and a falling edge before `dout` is sampled. For the polarity requirement, `dout` is instead sampled between the two edges, so a write on the wrong edge is caught. The registered outputs are due one active or opposite edge after the address change, and the bench samples `qout` one nanosecond after each of the two edges in turn to show when the value moves.

// File: rtl/dram_pkg.sv
package dram_pkg;

    localparam int HALF_AW    = 4;
    localparam int HALF_DEPTH = 1 << HALF_AW;
    localparam int N_HALVES   = 2;

    typedef enum logic [1:0] {
        OSEL_DIRECT  = 2'd0,
        OSEL_SAME    = 2'd1,
        OSEL_OPP     = 2'd2,
        OSEL_DIRECT2 = 2'd3
    } osel_e;

    // Write enable for a given half: narrow mode writes both, wide mode
    // writes the half chosen by the top address bit.
    function automatic logic half_wen(input logic we, input logic wide,
                                      input logic top_bit, input logic idx);
        return we && (!wide || (top_bit == idx));
    endfunction

endpackage

// File: rtl/dram_half.sv
module dram_half #(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wen,
    input  logic [AW-1:0] addr,
    input  logic          wdata,
    output logic          rdata
);
    localparam int DEPTH = 1 << AW;

    logic cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (wen) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/dram_merge.sv
module dram_merge (
    input  logic [1:0] half_rd,
    input  logic       wide,
    input  logic       top_bit,
    output logic [1:0] rd
);
    always_comb begin
        if (wide) begin
            rd[0] = top_bit ? half_rd[1] : half_rd[0];
            rd[1] = 1'b0;
        end else begin
            rd = half_rd;
        end
    end
endmodule

// File: rtl/dram_oreg.sv
module dram_oreg #(
    parameter int W = 2
) (
    input  logic         cclk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge cclk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/cfg_dist_ram.sv
module cfg_dist_ram
    import dram_pkg::*;
#(
    parameter int AW = dram_pkg::HALF_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wide,
    input  logic          cfg_fall,
    input  logic [1:0]    oreg_sel,
    input  logic          we,
    input  logic [AW-1:0] addr_f,
    input  logic [AW-1:0] addr_g,
    input  logic          din0,
    input  logic          din1,
    output logic [1:0]    dout,
    output logic [1:0]    qout
);
    logic       wclk;
    logic       oclk;
    logic [1:0] half_rd;
    logic [1:0] q_same;
    logic [1:0] q_opp;
    osel_e      osel;

    assign wclk = clk ^ cfg_fall;
    assign oclk = ~wclk;
    assign osel = osel_e'(oreg_sel);

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        logic          h_wen;
        logic [AW-1:0] h_addr;
        logic          h_data;

        if (h == 0) begin : g_lo
            assign h_addr = addr_f;
            assign h_data = din0;
        end else begin : g_hi
            assign h_addr = cfg_wide ? addr_f : addr_g;
            assign h_data = cfg_wide ? din0 : din1;
        end

        assign h_wen = half_wen(we, cfg_wide, din1, 1'(h));

        dram_half #(.AW(AW)) u_half (
            .wclk  (wclk),
            .wen   (h_wen),
            .addr  (h_addr),
            .wdata (h_data),
            .rdata (half_rd[h])
        );
    end

    dram_merge u_merge (
        .half_rd (half_rd),
        .wide    (cfg_wide),
        .top_bit (din1),
        .rd      (dout)
    );

    dram_oreg #(.W(2)) u_oreg_same (
        .cclk (wclk),
        .rst  (rst),
        .d    (dout),
        .q    (q_same)
    );

    dram_oreg #(.W(2)) u_oreg_opp (
        .cclk (oclk),
        .rst  (rst),
        .d    (dout),
        .q    (q_opp)
    );

    always_comb begin
        unique case (osel)
            OSEL_SAME: qout = q_same;
            OSEL_OPP:  qout = q_opp;
            default:   qout = dout;
        endcase
    end
endmodule

// File: rtl/dram_chk.sv
module dram_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wide,
    input logic       cfg_fall,
    input logic [1:0] oreg_sel,
    input logic       we,
    input logic [3:0] addr_f,
    input logic [3:0] addr_g,
    input logic       din0,
    input logic       din1,
    input logic [1:0] dout,
    input logic [1:0] qout
);
    logic aclk;
    assign aclk = clk ^ cfg_fall;

    assert_narrow_write_R1: assert property (@(posedge aclk) disable iff (rst)
        (we && !cfg_wide) |=>
        ((!cfg_wide && addr_f == $past(addr_f) && addr_g == $past(addr_g))
         -> (dout == {$past(din1), $past(din0)})));

    assert_wide_write_R3: assert property (@(posedge aclk) disable iff (rst)
        (we && cfg_wide) |=>
        ((cfg_wide && addr_f == $past(addr_f) && din1 == $past(din1))
         -> (dout[0] == $past(din0))));

    assert_wide_upper_zero_R4: assert property (@(posedge aclk) disable iff (rst)
        cfg_wide |-> (dout[1] == 1'b0));

    assert_no_write_hold_R5: assert property (@(posedge aclk) disable iff (rst)
        (!we) |=>
        ((addr_f == $past(addr_f) && addr_g == $past(addr_g) &&
          din1 == $past(din1) && cfg_wide == $past(cfg_wide))
         -> (dout == $past(dout))));

    assert_direct_out_R7: assert property (@(posedge clk) disable iff (rst)
        (oreg_sel == 2'd0 || oreg_sel == 2'd3) |-> (qout == dout));

    assert_same_edge_out_R7: assert property (@(posedge aclk) disable iff (rst)
        (oreg_sel == 2'd1) |=> ((oreg_sel == 2'd1) -> (qout == $past(dout))));

    assert_opp_edge_out_R7: assert property (@(negedge aclk) disable iff (rst)
        (oreg_sel == 2'd2) |=> ((oreg_sel == 2'd2) -> (qout == $past(dout))));

    assert_same_reset_R8: assert property (@(posedge aclk)
        rst |=> ((oreg_sel == 2'd1) -> (qout == 2'b00)));

    assert_opp_reset_R8: assert property (@(negedge aclk)
        rst |=> ((oreg_sel == 2'd2) -> (qout == 2'b00)));
endmodule

bind cfg_dist_ram dram_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_wide (cfg_wide),
    .cfg_fall (cfg_fall),
    .oreg_sel (oreg_sel),
    .we       (we),
    .addr_f   (addr_f),
    .addr_g   (addr_g),
    .din0     (din0),
    .din1     (din1),
    .dout     (dout),
    .qout     (qout)
);

// File: tb/cfg_dist_ram_tb_top.sv
`timescale 1ns/1ps
module cfg_dist_ram_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wide = 1'b0;
    logic       cfg_fall = 1'b0;
    logic [1:0] oreg_sel = 2'd0;
    logic       we = 1'b0;
    logic [3:0] addr_f = '0;
    logic [3:0] addr_g = '0;
    logic       din0 = 1'b0;
    logic       din1 = 1'b0;
    logic [1:0] dout;
    logic [1:0] qout;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    logic model [32];

    always #2.5 clk = ~clk;

    cfg_dist_ram dut_i (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_fall(cfg_fall),
        .oreg_sel(oreg_sel), .we(we), .addr_f(addr_f), .addr_g(addr_g),
        .din0(din0), .din1(din1), .dout(dout), .qout(qout)
    );

    // {we, addr_f, addr_g, din0, din1, expected dout[1:0]}
    localparam logic [12:0] VEC [10] = '{
        {1'b1, 4'd3,  4'd5,  1'b1, 1'b0, 2'b01},
        {1'b1, 4'd5,  4'd3,  1'b0, 1'b1, 2'b10},
        {1'b0, 4'd3,  4'd3,  1'b0, 1'b0, 2'b11},
        {1'b1, 4'd15, 4'd15, 1'b1, 1'b1, 2'b11},
        {1'b1, 4'd0,  4'd0,  1'b1, 1'b1, 2'b11},
        {1'b0, 4'd15, 4'd0,  1'b0, 1'b0, 2'b11},
        {1'b1, 4'd3,  4'd0,  1'b0, 1'b0, 2'b00},
        {1'b0, 4'd5,  4'd5,  1'b1, 1'b1, 2'b00},
        {1'b1, 4'd9,  4'd9,  1'b1, 1'b0, 2'b01},
        {1'b0, 4'd9,  4'd3,  1'b0, 1'b0, 2'b11}
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one operation held across one rising and one falling edge.
    task automatic apply(input logic w, input logic [3:0] af, input logic [3:0] ag,
                         input logic d0, input logic d1);
        @(posedge clk); #1;
        addr_f = af; addr_g = ag; din0 = d0; din1 = d1; we = w;
        @(negedge clk);
        @(posedge clk); #1;
        we = 1'b0;
        if (w) begin
            if (cfg_wide) model[{d1, af}] = d0;
            else begin
                model[{1'b0, af}] = d0;
                model[{1'b1, ag}] = d1;
            end
        end
        @(negedge clk); #1;
    endtask

    task automatic pulse_reset();
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    function automatic logic pat(input int w);
        return logic'(((w * 7) >> 2) & 1);
    endfunction

    initial begin : watchdog
        #100000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic a_val;
        logic b_val;
        repeat (3) @(posedge clk);
        #1;
        oreg_sel = 2'd1;
        #0.5 check("R8 reset same-edge reg", qout, 2'b00);
        oreg_sel = 2'd2;
        #0.5 check("R8 reset opposite-edge reg", qout, 2'b00);
        oreg_sel = 2'd0;
        rst = 1'b0;

        // Narrow mode, rising edge: clear, then walk the vector table (R1, R2, R5)
        for (int i = 0; i < 16; i++) apply(1'b1, 4'(i), 4'(i), 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) begin
            apply(VEC[i][12], VEC[i][11:8], VEC[i][7:4], VEC[i][3], VEC[i][2]);
            check(VEC[i][12] ? "R1 R2 narrow write/read" : "R5 no write", dout, VEC[i][1:0]);
        end

        // Cross-half combinational reads, no clock edge in between (R2)
        for (int i = 0; i < 16; i++) begin
            addr_f = 4'(i); addr_g = 4'(15 - i); #0.2;
            check("R2 async read", dout, {model[{1'b1, 4'(15 - i)}], model[{1'b0, 4'(i)}]});
        end

        // Rising polarity: nothing written on falling edge (R6)
        @(posedge clk); #1;
        addr_f = 4'd7; din0 = ~model[7]; we = 1'b1;
        @(negedge clk); #1;
        check("R6 rising: not on falling edge", {1'b0, dout[0]}, {1'b0, model[7]});
        @(posedge clk); #1;
        we = 1'b0; model[7] = din0;
        check("R6 rising: written on rising edge", {1'b0, dout[0]}, {1'b0, model[7]});

        // Output path selection (R7)
        apply(1'b1, 4'd1, 4'd1, 1'b1, 1'b0);
        apply(1'b1, 4'd2, 4'd2, 1'b0, 1'b1);
        a_val = model[1]; b_val = model[2];
        oreg_sel = 2'd1; addr_f = 4'd1;
        @(posedge clk); @(posedge clk); #1;
        addr_f = 4'd2;
        @(negedge clk); #1;
        check("R7 same-edge holds until active edge", {1'b0, qout[0]}, {1'b0, a_val});
        @(posedge clk); #1;
        check("R7 same-edge updates on active edge", {1'b0, qout[0]}, {1'b0, b_val});
        oreg_sel = 2'd2; addr_f = 4'd1;
        @(negedge clk); #1;
        check("R7 opposite-edge updates on opposite edge", {1'b0, qout[0]}, {1'b0, a_val});
        addr_f = 4'd2;
        @(posedge clk); #1;
        check("R7 opposite-edge holds at active edge", {1'b0, qout[0]}, {1'b0, a_val});
        oreg_sel = 2'd3; #0.2;
        check("R7 select 3 is direct", qout, dout);
        oreg_sel = 2'd0; addr_f = 4'd1; #0.2;
        check("R7 select 0 is direct", qout, {model[{1'b1, 4'd2}], a_val});

        // Reset clears registers, keeps memory (R8)
        oreg_sel = 2'd1;
        pulse_reset();
        addr_f = 4'd3; addr_g = 4'd9; #0.2;
        check("R8 memory kept across reset", dout, {model[25], model[3]});

        // Wide mode (R3, R4): cross-mode mapping, then fill and read
        oreg_sel = 2'd0;
        rst = 1'b1; cfg_wide = 1'b1;
        pulse_reset();
        for (int w = 0; w < 32; w++) begin
            addr_f = 4'(w); din1 = logic'(w >> 4); #0.2;
            check("R3 R4 wide view of narrow data", dout, {1'b0, model[w]});
        end
        for (int w = 0; w < 32; w++) apply(1'b1, 4'(w), 4'(31 - w), pat(w), logic'(w >> 4));
        for (int w = 31; w >= 0; w--) begin
            addr_f = 4'(w); din1 = logic'(w >> 4); addr_g = 4'(w); #0.2;
            check("R3 R4 wide read", dout, {1'b0, model[w]});
        end
        apply(1'b0, 4'd4, 4'd4, ~model[20], 1'b1);
        check("R5 wide no write", dout, {1'b0, model[20]});

        // Falling polarity, narrow (R6)
        rst = 1'b1; cfg_wide = 1'b0; cfg_fall = 1'b1;
        pulse_reset();
        @(negedge clk); #1;
        addr_f = 4'd6; addr_g = 4'd6; din0 = ~model[6]; din1 = ~model[22]; we = 1'b1;
        @(posedge clk); #1;
        check("R6 falling: not on rising edge", dout, {model[22], model[6]});
        @(negedge clk); #1;
        we = 1'b0; model[6] = din0; model[22] = din1;
        check("R6 falling: written on falling edge", dout, {model[22], model[6]});
        apply(1'b1, 4'd11, 4'd12, 1'b1, 1'b0);
        check("R1 falling-edge narrow write", dout, {model[28], model[11]});

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule